// File: doc/BRIEF.md
# Processor Power-Up Sequencer

This block is a hardware state machine that takes a processor subsystem from full reset to executing code. It is triggered by a single-cycle start request. It then walks a fixed, ordered list of steps on its control outputs: reset lines, crystal-clock branch enable, power-control word, per-bank memory enables and core clock. Each step takes at least one clock cycle, and no two steps ever land in the same cycle. Timed waits are counted from a 1 µs tick input. The clock-ready check polls a clock-off status input under a bounded timeout.

The head switch, the regulator, the memories and the processor sit outside the block. They only see its output bits. Once the start request is taken, the block latches the boot address and presents it as a boot vector, shifted right by four bits. It ends each attempt with a one-cycle done pulse or a one-cycle error pulse, then goes back to idle.

Top module: `core_powerup_seq`

## Requirements
- R1: After reset the outputs are as follows. The reset control word is 0 and the crystal-clock enable is 0. The power-control word has only bits 20, 21 and 22 set. All memory banks are off, the core clock is off, the boot vector is 0, and done and error are low.
- R2: A start request taken in idle sets reset-control bits 0 (stop core), 1 (core reset) and 2 (bus reset) in one step. The same step restores the power word, the banks, the crystal enable and the core clock to their R1 values. The crystal-clock enable rises in the next step.
- R3: The block then polls the clock-off input. The sequence continues as soon as that input is low. If the input is still high at the 200th tick after polling began, one error pulse is issued. With 199 such ticks the sequence succeeds.
- R4: After the clock is ready, power bit 24 (head switch) is set. Power bit 25 (regulator bypass) follows only after at least one tick.
- R5: Next, power bit 22 (compiler-memory clamp) is cleared. Then bits 18 and 19 (standby-not and retention-not) are set together in one step.
- R6: Memory banks are enabled one per step, from bank NBANK-1 down to bank 0. At least one tick passes after each bank enable before the next step.
- R7: After the last bank, power bit 21 (word-line clamp) is cleared, and then bit 20 (I/O clamp) is cleared, as two separate steps.
- R8: Reset-control bit 1 is cleared first, then the core clock is enabled, then reset-control bit 0 is cleared. Each is a separate step.
- R9: The boot vector equals the boot address shifted right by 4. It is captured in the step after the start request is taken. Later changes of the address input have no effect until the next start.
- R10: A start request that arrives while a sequence is running has no effect on the outputs or on the outcome.
- R11: Done and error are single-cycle pulses that never occur together. After either one, the block accepts a new start request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start pulse, taken only in idle |
| tickUs | input | 1 | One-cycle pulse every microsecond |
| clkOffStatus | input | 1 | High while the crystal clock branch is still off |
| bootAddr | input | ADDR_W | Boot address to be latched at start |
| rstCtrl | output | 3 | Bit 0 stop core, bit 1 core reset, bit 2 bus reset |
| xoClkEn | output | 1 | Crystal-clock branch enable |
| pwrCtrl | output | 32 | Power-control word (bits 18..22, 24, 25 used) |
| memBankEn | output | NBANK | Per-bank memory power enable |
| coreClkEn | output | 1 | Core clock enable |
| bootVec | output | ADDR_W | Boot address shifted right by 4 |
| seqDone | output | 1 | One-cycle pulse when the core is released |
| seqError | output | 1 | One-cycle pulse on clock-ready timeout |

## Verification
The assertions assume the following about the inputs:
- The tick input is a one-cycle pulse separated by idle cycles.
- The clock-off status input changes only while the poll is in progress.
- Reset is held low before the first clock edge.

The stimulus follows these rules. The tick is produced by a free-running divider, so every tick is one cycle wide. The clock-off responder counts only ticks seen while the crystal enable is high and the responder is still reporting clock off. Its counter is cleared from the moment the start request is sent until the reset step is observed, so ticks from an earlier attempt never reach a new poll.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  // Reset control word bit positions
  localparam int RST_STOP = 0;
  localparam int RST_CORE = 1;
  localparam int RST_BUS  = 2;

  // Power control word bit positions (decoded by the power switch fabric)
  localparam int PWR_STBY_N   = 18;
  localparam int PWR_RET_N    = 19;
  localparam int PWR_IO_CLAMP = 20;
  localparam int PWR_WL_CLAMP = 21;
  localparam int PWR_QMC_CLAMP = 22;
  localparam int PWR_HEADSW   = 24;
  localparam int PWR_LDO_BYP  = 25;

  localparam logic [31:0] PWR_RESET =
    (32'd1 << PWR_IO_CLAMP) | (32'd1 << PWR_WL_CLAMP) | (32'd1 << PWR_QMC_CLAMP);

  typedef struct packed {
    logic setRst;
    logic xoOn;
    logic hsOn;
    logic ldoOn;
    logic clrQmc;
    logic setStby;
    logic bankOn;
    logic clrWl;
    logic clrIo;
    logic relCore;
    logic clkOn;
    logic relStop;
  } seqStrobe_t;

  typedef enum logic [4:0] {
    S_IDLE, S_RST, S_XO, S_POLL, S_FAIL, S_HS, S_HSW, S_LDO, S_QMC,
    S_STBY, S_BANK, S_BANKW, S_WL, S_IO, S_CORE, S_CLK, S_GO, S_DONE
  } seqState_t;

endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int NBANK      = 20,
  parameter int POLL_LIMIT = 200
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startReq,
  input  logic                     tickUs,
  input  logic                     clkOffStatus,
  output seqStrobe_t               strobe,
  output logic [((NBANK > 1) ? $clog2(NBANK) : 1)-1:0] bankIdx,
  output logic                     seqDone,
  output logic                     seqError
);

  localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int CNT_W  = $clog2(POLL_LIMIT + 1);

  seqState_t state, nextState;
  logic [CNT_W-1:0] pollCnt;

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE:  if (startReq) nextState = S_RST;
      S_RST:   nextState = S_XO;
      S_XO:    nextState = S_POLL;
      S_POLL: begin
        if (!clkOffStatus) nextState = S_HS;
        else if (tickUs && pollCnt == CNT_W'(1)) nextState = S_FAIL;
      end
      S_FAIL:  nextState = S_IDLE;
      S_HS:    nextState = S_HSW;
      S_HSW:   if (tickUs) nextState = S_LDO;
      S_LDO:   nextState = S_QMC;
      S_QMC:   nextState = S_STBY;
      S_STBY:  nextState = S_BANK;
      S_BANK:  nextState = S_BANKW;
      S_BANKW: if (tickUs) nextState = (bankIdx == '0) ? S_WL : S_BANK;
      S_WL:    nextState = S_IO;
      S_IO:    nextState = S_CORE;
      S_CORE:  nextState = S_CLK;
      S_CLK:   nextState = S_GO;
      S_GO:    nextState = S_DONE;
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pollCnt <= '0;
      bankIdx <= '0;
    end else begin
      state <= nextState;
      if (state == S_XO) pollCnt <= CNT_W'(POLL_LIMIT);
      else if (state == S_POLL && clkOffStatus && tickUs) pollCnt <= pollCnt - 1'b1;
      if (state == S_STBY) bankIdx <= BIDX_W'(NBANK - 1);
      else if (state == S_BANKW && tickUs && bankIdx != '0) bankIdx <= bankIdx - 1'b1;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.setRst  = (state == S_RST);
    strobe.xoOn    = (state == S_XO);
    strobe.hsOn    = (state == S_HS);
    strobe.ldoOn   = (state == S_LDO);
    strobe.clrQmc  = (state == S_QMC);
    strobe.setStby = (state == S_STBY);
    strobe.bankOn  = (state == S_BANK);
    strobe.clrWl   = (state == S_WL);
    strobe.clrIo   = (state == S_IO);
    strobe.relCore = (state == S_CORE);
    strobe.clkOn   = (state == S_CLK);
    strobe.relStop = (state == S_GO);
  end

  assign seqDone  = (state == S_DONE);
  assign seqError = (state == S_FAIL);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone); // R11
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    seqError |=> !seqError); // R11
  AST_POLL_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_POLL) |-> (pollCnt != '0)); // R3
  AST_ERR_FROM_POLL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqError) |-> ($past(state) == S_POLL)); // R3
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |=> (state != S_RST)); // R10

endmodule

// File: rtl/pwrseq_datapath.sv
module pwrseq_datapath
  import pwrseq_pkg::*;
#(
  parameter int NBANK  = 20,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [((NBANK > 1) ? $clog2(NBANK) : 1)-1:0] bankIdx,
  input  logic [ADDR_W-1:0] bootAddr,
  output logic [2:0]        rstCtrl,
  output logic              xoClkEn,
  output logic [31:0]       pwrCtrl,
  output logic [NBANK-1:0]  memBankEn,
  output logic              coreClkEn,
  output logic [ADDR_W-1:0] bootVec
);

  localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCtrl   <= '0;
      xoClkEn   <= 1'b0;
      pwrCtrl   <= PWR_RESET;
      coreClkEn <= 1'b0;
      bootVec   <= '0;
    end else if (strobe.setRst) begin
      rstCtrl   <= 3'b111;
      xoClkEn   <= 1'b0;
      pwrCtrl   <= PWR_RESET;
      coreClkEn <= 1'b0;
      bootVec   <= bootAddr >> 4;
    end else begin
      if (strobe.xoOn)    xoClkEn <= 1'b1;
      if (strobe.hsOn)    pwrCtrl[PWR_HEADSW] <= 1'b1;
      if (strobe.ldoOn)   pwrCtrl[PWR_LDO_BYP] <= 1'b1;
      if (strobe.clrQmc)  pwrCtrl[PWR_QMC_CLAMP] <= 1'b0;
      if (strobe.setStby) begin
        pwrCtrl[PWR_STBY_N] <= 1'b1;
        pwrCtrl[PWR_RET_N]  <= 1'b1;
      end
      if (strobe.clrWl)   pwrCtrl[PWR_WL_CLAMP] <= 1'b0;
      if (strobe.clrIo)   pwrCtrl[PWR_IO_CLAMP] <= 1'b0;
      if (strobe.relCore) rstCtrl[RST_CORE] <= 1'b0;
      if (strobe.clkOn)   coreClkEn <= 1'b1;
      if (strobe.relStop) rstCtrl[RST_STOP] <= 1'b0;
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : gBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) memBankEn[g] <= 1'b0;
      else if (strobe.setRst) memBankEn[g] <= 1'b0;
      else if (strobe.bankOn && bankIdx == BIDX_W'(g)) memBankEn[g] <= 1'b1;
    end
  end

  // Enabled banks always form one contiguous run ending at the top bank
  AST_BANKS_CONTIG: assert property (@(posedge clk) disable iff (!rstN)
    (((~memBankEn) & ((~memBankEn) + 1'b1)) == '0)); // R6
  AST_LDO_NEEDS_HS: assert property (@(posedge clk) disable iff (!rstN)
    pwrCtrl[PWR_LDO_BYP] |-> pwrCtrl[PWR_HEADSW]); // R4
  AST_IO_AFTER_WL: assert property (@(posedge clk) disable iff (!rstN)
    !pwrCtrl[PWR_IO_CLAMP] |-> !pwrCtrl[PWR_WL_CLAMP]); // R7
  AST_CLK_AFTER_REL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreClkEn) |-> !rstCtrl[RST_CORE]); // R8
  AST_STOP_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstCtrl[RST_STOP]) |-> coreClkEn); // R8

endmodule

// File: rtl/core_powerup_seq.sv
module core_powerup_seq
  import pwrseq_pkg::*;
#(
  parameter int NBANK      = 20,
  parameter int ADDR_W     = 32,
  parameter int POLL_LIMIT = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              tickUs,
  input  logic              clkOffStatus,
  input  logic [ADDR_W-1:0] bootAddr,
  output logic [2:0]        rstCtrl,
  output logic              xoClkEn,
  output logic [31:0]       pwrCtrl,
  output logic [NBANK-1:0]  memBankEn,
  output logic              coreClkEn,
  output logic [ADDR_W-1:0] bootVec,
  output logic              seqDone,
  output logic              seqError
);

  localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  seqStrobe_t        strobe;
  logic [BIDX_W-1:0] bankIdx;

  pwrseq_ctrl #(.NBANK(NBANK), .POLL_LIMIT(POLL_LIMIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tickUs(tickUs),
    .clkOffStatus(clkOffStatus), .strobe(strobe), .bankIdx(bankIdx),
    .seqDone(seqDone), .seqError(seqError)
  );

  pwrseq_datapath #(.NBANK(NBANK), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankIdx(bankIdx),
    .bootAddr(bootAddr), .rstCtrl(rstCtrl), .xoClkEn(xoClkEn),
    .pwrCtrl(pwrCtrl), .memBankEn(memBankEn), .coreClkEn(coreClkEn),
    .bootVec(bootVec)
  );

endmodule

// File: tb/core_powerup_seq_tb_top.sv
module core_powerup_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 20;
  localparam int TICK_DIV   = 4;
  localparam int LAST       = 11 + NB;
  localparam int SNAP_W     = 3 + 1 + 32 + NB + 1;
  localparam int NVEC       = 5;

  localparam int          VEC_POLL[NVEC] = '{0, 3, 199, 200, 260};
  localparam logic [31:0] VEC_ADDR[NVEC] = '{32'h8000_0000, 32'h1234_5678,
                                             32'hFFFF_FFF0, 32'h0000_00AB, 32'hDEAD_BEEF};
  localparam bit          VEC_ERR[NVEC]  = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic tickUs = 1'b0;
  logic clkOffStatus;
  logic [31:0] bootAddr = '0;
  logic [2:0]  rstCtrl;
  logic        xoClkEn;
  logic [31:0] pwrCtrl;
  logic [NB-1:0] memBankEn;
  logic        coreClkEn;
  logic [31:0] bootVec;
  logic        seqDone, seqError;

  int tickDiv = 0;
  int tickCount = 0;
  int pollSeen = 0;
  int pollTarget = 0;
  bit clrPoll = 1'b1;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_powerup_seq #(.NBANK(NB), .ADDR_W(32), .POLL_LIMIT(200)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tickUs(tickUs),
    .clkOffStatus(clkOffStatus), .bootAddr(bootAddr), .rstCtrl(rstCtrl),
    .xoClkEn(xoClkEn), .pwrCtrl(pwrCtrl), .memBankEn(memBankEn),
    .coreClkEn(coreClkEn), .bootVec(bootVec), .seqDone(seqDone),
    .seqError(seqError)
  );

  // Tick source and clock-off responder
  always @(posedge clk) begin
    tickDiv <= (tickDiv == TICK_DIV - 1) ? 0 : tickDiv + 1;
    tickUs  <= (tickDiv == TICK_DIV - 2);
    if (tickUs) tickCount <= tickCount + 1;
    if (clrPoll) pollSeen <= 0;
    else if (xoClkEn && tickUs && clkOffStatus) pollSeen <= pollSeen + 1;
  end
  assign clkOffStatus = (pollSeen < pollTarget);

  function automatic logic [SNAP_W-1:0] snap(int k);
    logic [2:0] r; logic x; logic [31:0] p; logic [NB-1:0] b; logic c;
    r = '0; x = 1'b0; p = 32'h0070_0000; b = '0; c = 1'b0;
    for (int s = 1; s <= k; s++) begin
      if (s == 1) r = 3'b111;
      else if (s == 2) x = 1'b1;
      else if (s == 3) p[24] = 1'b1;
      else if (s == 4) p[25] = 1'b1;
      else if (s == 5) p[22] = 1'b0;
      else if (s == 6) begin p[18] = 1'b1; p[19] = 1'b1; end
      else if (s <= 6 + NB) b[NB - 1 - (s - 7)] = 1'b1;
      else if (s == 7 + NB) p[21] = 1'b0;
      else if (s == 8 + NB) p[20] = 1'b0;
      else if (s == 9 + NB) r[1] = 1'b0;
      else if (s == 10 + NB) c = 1'b1;
      else r[0] = 1'b0;
    end
    return {r, x, p, b, c};
  endfunction

  function automatic bit needsTick(int s);
    return (s == 4) || (s >= 8 && s <= 7 + NB);
  endfunction

  function automatic logic [SNAP_W-1:0] outsNow();
    return {rstCtrl, xoClkEn, pwrCtrl, memBankEn, coreClkEn};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runSeq(int pt, logic [31:0] addr, bit expErr, bit midStart);
    int idx = 0, cyc = 0, doneCnt = 0, errCnt = 0, orderFails = 0;
    int waitFails = 0, mark = 0, after = 0;
    bit fresh = 1'b1, injected = 1'b0;
    pollTarget = pt;
    clrPoll = 1'b1;
    bootAddr = addr;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    while (cyc < 6000 && after < 4) begin
      if (fresh) begin
        if (outsNow() == snap(1)) begin
          idx = 1; fresh = 1'b0; clrPoll = 1'b0; bootAddr = ~addr; mark = tickCount;
        end else if (cyc > 3) begin
          orderFails++; fresh = 1'b0;
        end
      end else if (outsNow() != snap(idx)) begin
        if (idx < LAST && outsNow() == snap(idx + 1)) begin
          if (needsTick(idx + 1) && tickCount == mark) waitFails++;
          idx++;
          mark = tickCount;
        end else orderFails++;
      end
      if (seqDone) doneCnt++;
      if (seqError) errCnt++;
      if (doneCnt + errCnt > 0) after++;
      startReq = midStart && idx == 10 && !injected;
      if (startReq) injected = 1'b1;
      @(negedge clk);
      cyc++;
    end
    startReq = 1'b0;
    // R2 R4 R5 R6 R7 R8: every output change is the next step of the ordered list
    check(orderFails == 0, "R2/R5/R7/R8", "step order violations", orderFails, 0);
    check(waitFails == 0, "R4/R6", "steps taken without a tick wait", waitFails, 0);
    check(idx == (expErr ? 2 : LAST), expErr ? "R3" : "R8", "final step reached",
          idx, expErr ? 2 : LAST);
    check(errCnt == (expErr ? 1 : 0), "R3", "error pulse cycles", errCnt, expErr ? 1 : 0);
    check(doneCnt == (expErr ? 0 : 1), "R11", "done pulse cycles", doneCnt, expErr ? 0 : 1);
    check(bootVec == (addr >> 4), "R9", "boot vector", bootVec, addr >> 4);
    if (midStart) check(injected && doneCnt == 1, "R10", "busy start ignored", doneCnt, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outsNow() == snap(0), "R1", "outputs after reset", outsNow(), snap(0));
    check(!seqDone && !seqError && bootVec == 0, "R1", "done/error/vector after reset",
          {seqDone, seqError}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outsNow() == snap(0), "R1", "idle outputs before start", outsNow(), snap(0));

    // Vector table walk (back-to-back runs also cover R11 restart)
    for (int v = 0; v < NVEC; v++)
      runSeq(VEC_POLL[v], VEC_ADDR[v], VEC_ERR[v], 1'b0);

    // R10: start pulse during the bank phase
    runSeq(2, 32'h0000_1230, 1'b0, 1'b1);

    // R1: reset in the middle of a sequence returns to the reset state
    pollTarget = 0;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    repeat (12) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(outsNow() == snap(0), "R1", "outputs after mid-run reset", outsNow(), snap(0));
    rstN = 1'b1;
    @(negedge clk);

    // R11: a fresh start after reset completes normally
    runSeq(1, 32'h0000_0010, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule